// File: doc/BRIEF.md
# Four-Channel DMA Grant Arbiter

This block chooses which of four DMA channels may drive the bus for its next transfer unit. Each channel raises a request line. The arbiter issues a registered one-hot grant and holds it until the owning channel reports that its unit is finished. A new choice is made only while no unit is in flight. Choosing a winner and releasing the bus each take one clock edge, so there is always one idle cycle between two units.

The ranking comes from a control register. It holds a master enable, a 2-bit order select and two sticky fault flags, one for an address error and one for a non-maskable interrupt. Three order codes give fixed rankings and the fourth gives rotating fairness. A fault flag is raised by a one-cycle input pulse. Software clears it by writing zero to it through the register port. While the enable is low or either flag is up, the grant outputs are forced to zero and any held grant is dropped.

Top module: `dma_grant_arbiter`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) leaves `gnt` = 0, `gnt_valid` = 0, `st_en` = 0, `st_mode` = 00, `st_aerr` = 0 and `st_nmi` = 0, with the rotation start pointing at channel 0.
- R2: With order code 00, the requesting channel with the best rank wins, ranked channel 0 first, then 1, then 2, then 3. Bit i of `req` and of `gnt` belongs to channel i.
- R3: With order code 01, the ranking is channel 0, then 2, then 3, then 1.
- R4: With order code 10, the ranking is channel 2, then 0, then 1, then 3.
- R5: With order code 11, the search starts at the rotation pointer and rises through the channel numbers, wrapping from 3 to 0. Every new grant to channel k (in any order mode) moves the pointer to k+1 mod 4. The pointer does not move in any other cycle.
- R6: When the arbiter is idle and enabled and some `req` bit is high at a clock edge, the grant appears after that edge. It then stays unchanged, whatever happens to `req` or the order code, until an edge at which `unit_done` is high. After that edge `gnt` is 0 for at least one cycle.
- R7: While `st_en` is 0, `gnt` is 0. Clearing the enable discards a held grant, so the grant does not come back when the enable returns.
- R8: A high `aerr_set` at an edge sets `st_aerr` after that edge. While `st_aerr` is 1, `gnt` is 0, and any held grant is discarded.
- R9: A high `nmi_set` at an edge sets `st_nmi` after that edge. While `st_nmi` is 1, `gnt` is 0, and any held grant is discarded.
- R10: A register write (`cfg_we` high) loads `cfg_en` and `cfg_mode`. For each fault flag, a written 0 clears it and a written 1 leaves it as it was. A set pulse in the same cycle as a clearing write leaves the flag set.
- R11: `gnt` never has more than one bit set, and `gnt_valid` is high exactly when `gnt` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 4 | Per-channel transfer requests |
| unit_done | input | 1 | The granted channel has finished its unit |
| cfg_we | input | 1 | Control register write strobe |
| cfg_en | input | 1 | Master enable value to write |
| cfg_mode | input | 2 | Order code to write |
| cfg_aerr | input | 1 | Address-error flag write value (0 clears) |
| cfg_nmi | input | 1 | NMI flag write value (0 clears) |
| aerr_set | input | 1 | Address-error set pulse |
| nmi_set | input | 1 | NMI set pulse |
| gnt | output | 4 | One-hot grant |
| gnt_valid | output | 1 | A grant is active |
| st_en | output | 1 | Current master enable |
| st_mode | output | 2 | Current order code |
| st_aerr | output | 1 | Current address-error flag |
| st_nmi | output | 1 | Current NMI flag |

## Verification
The bench targets the cases where the non-sequential orders differ from plain numeric ranking. One case is channel 3 beating channel 1 under code 01. Another is channel 2 beating channels 0 and 1 under code 10. A design with a misdecoded order table would grant the lower-numbered channel in these cases. Rotation is tested across the wrap from channel 3 back to 0 and also after grants made in fixed modes. A pointer that moved on idle cycles, or did not wrap, would grant the wrong channel.

The bench also checks that a held grant ignores request and order changes until `unit_done`. It checks that a fault or a cleared enable kills the grant at once and that the grant does not come back afterwards. It checks that a write of 1, or a clearing write that coincides with a set pulse, leaves a flag standing. A design that resumed stale grants, or that let the clearing write win over the set pulse, would show a grant or a flag value that differs from the model.

// File: rtl/dmarb_pkg.sv
// Shared constants, the order-code type and the rank lookup for the DMA
// grant arbiter. Assumes exactly four channels, as the fixed orders are
// defined for four.
package dmarb_pkg;
    localparam int NCH = 4;
    localparam int CHW = $clog2(NCH);

    typedef logic [CHW-1:0] chan_t;

    typedef enum logic [1:0] {
        ORD_0123   = 2'b00,
        ORD_0231   = 2'b01,
        ORD_2013   = 2'b10,
        ORD_ROTATE = 2'b11
    } order_e;

    // Channel that holds rank position pos (0 = best) under a given order.
    function automatic chan_t chan_at(order_e ord, chan_t base, int unsigned pos);
        chan_t p;
        p = chan_t'(pos);
        case (ord)
            ORD_0123: return p;
            ORD_0231: begin
                case (p)
                    2'd0:    return 2'd0;
                    2'd1:    return 2'd2;
                    2'd2:    return 2'd3;
                    default: return 2'd1;
                endcase
            end
            ORD_2013: begin
                case (p)
                    2'd0:    return 2'd2;
                    2'd1:    return 2'd0;
                    2'd2:    return 2'd1;
                    default: return 2'd3;
                endcase
            end
            default: return chan_t'(base + p);
        endcase
    endfunction
endpackage

// File: rtl/dmarb_ctrl.sv
// Control register of the arbiter: master enable, order code and two
// sticky fault flags. Assumes the set pulses last one cycle. Each flag is
// cleared only by a write of zero, and a set pulse wins over a clear in
// the same cycle.
module dmarb_ctrl
    import dmarb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  logic   wr_enable,
    input  logic [1:0] wr_mode,
    input  logic   wr_aerr,
    input  logic   wr_nmi,
    input  logic   aerr_set,
    input  logic   nmi_set,
    output logic   en_q,
    output order_e mode_q,
    output logic   aerr_q,
    output logic   nmi_q,
    output logic   allow
);
    logic aerr_clr;
    logic nmi_clr;

    // A flag clears only on a write that carries a zero for it.
    assign aerr_clr = wr_en && !wr_aerr;
    assign nmi_clr  = wr_en && !wr_nmi;

    // Register state update; set pulses dominate clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= ORD_0123;
            aerr_q <= 1'b0;
            nmi_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                en_q   <= wr_enable;
                mode_q <= order_e'(wr_mode);
            end
            aerr_q <= aerr_set || (aerr_q && !aerr_clr);
            nmi_q  <= nmi_set  || (nmi_q  && !nmi_clr);
        end
    end

    // Grants are permitted only when enabled and fault-free.
    assign allow = en_q && !aerr_q && !nmi_q;

    assert_aerr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        aerr_set |=> aerr_q);
    assert_nmi_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_set |=> nmi_q);
    assert_aerr_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (aerr_q && !(wr_en && !wr_aerr)) |=> aerr_q);
    assert_nmi_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_q && !(wr_en && !wr_nmi)) |=> nmi_q);
endmodule

// File: rtl/dmarb_pick.sv
// Combinational winner selection. Builds the rank list for the current
// order code and rotation base, then takes the best-ranked requester.
// Assumes the caller ignores win when hit is low.
module dmarb_pick
    import dmarb_pkg::*;
(
    input  order_e           ord,
    input  chan_t            base,
    input  logic [NCH-1:0]   req,
    output logic             hit,
    output chan_t            win
);
    chan_t          cand [NCH];
    logic [NCH-1:0] cand_req;

    for (genvar pos = 0; pos < NCH; pos++) begin : g_rank
        // Channel at this rank position and whether it is requesting.
        assign cand[pos]     = chan_at(ord, base, pos);
        assign cand_req[pos] = req[cand[pos]];
    end

    // Scan from the worst rank up so the best requester is kept last.
    always_comb begin
        hit = |req;
        win = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand_req[i]) win = cand[i];
        end
    end
endmodule

// File: rtl/dmarb_grant.sv
// Grant holder and rotation pointer. Arbitrates only while idle, holds
// the grant until unit_done, and drops everything when allow falls.
// Assumes allow already combines the enable and both fault flags.
module dmarb_grant
    import dmarb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           allow,
    input  order_e         ord,
    input  logic [NCH-1:0] req,
    input  logic           unit_done,
    output logic [NCH-1:0] gnt_q,
    output logic           busy,
    output chan_t          ptr
);
    logic  hit;
    chan_t win;

    dmarb_pick u_pick (
        .ord  (ord),
        .base (ptr),
        .req  (req),
        .hit  (hit),
        .win  (win)
    );

    // Grant lifecycle: abort, release, or a new award while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            gnt_q <= '0;
            ptr   <= '0;
        end else if (!allow) begin
            busy  <= 1'b0;
            gnt_q <= '0;
        end else if (busy) begin
            if (unit_done) begin
                busy  <= 1'b0;
                gnt_q <= '0;
            end
        end else if (hit) begin
            busy  <= 1'b1;
            gnt_q <= {{(NCH-1){1'b0}}, 1'b1} << win;
            ptr   <= chan_t'(win + 1'b1);
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && allow && !unit_done) |=> (gnt_q == $past(gnt_q)));
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && unit_done) |=> (gnt_q == '0));
    assert_ptr_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy) |-> $stable(ptr));
endmodule

// File: rtl/dma_grant_arbiter.sv
// Top of the four-channel DMA grant arbiter. Ties the control register to
// the grant holder and gates the outputs with the permit signal so that a
// fault or a cleared enable removes the grant in the same cycle.
module dma_grant_arbiter
    import dmarb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] req,
    input  logic       unit_done,
    input  logic       cfg_we,
    input  logic       cfg_en,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_aerr,
    input  logic       cfg_nmi,
    input  logic       aerr_set,
    input  logic       nmi_set,
    output logic [3:0] gnt,
    output logic       gnt_valid,
    output logic       st_en,
    output logic [1:0] st_mode,
    output logic       st_aerr,
    output logic       st_nmi
);
    logic           allow;
    order_e         mode_q;
    logic [NCH-1:0] gnt_q;
    logic           busy;
    chan_t          ptr;

    dmarb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_enable (cfg_en),
        .wr_mode   (cfg_mode),
        .wr_aerr   (cfg_aerr),
        .wr_nmi    (cfg_nmi),
        .aerr_set  (aerr_set),
        .nmi_set   (nmi_set),
        .en_q      (st_en),
        .mode_q    (mode_q),
        .aerr_q    (st_aerr),
        .nmi_q     (st_nmi),
        .allow     (allow)
    );

    dmarb_grant u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .allow     (allow),
        .ord       (mode_q),
        .req       (req),
        .unit_done (unit_done),
        .gnt_q     (gnt_q),
        .busy      (busy),
        .ptr       (ptr)
    );

    // Output gating by the permit signal.
    assign gnt       = allow ? gnt_q : '0;
    assign gnt_valid = |gnt;
    assign st_mode   = mode_q;

    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_en_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_en |-> (gnt == '0));
    assert_flag_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_aerr || st_nmi) |-> !gnt_valid);
endmodule

// File: tb/dma_grant_arbiter_test.sv
module dma_grant_arbiter_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       unit_done = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_en = 1'b0;
    logic [1:0] cfg_mode = '0;
    logic       cfg_aerr = 1'b0;
    logic       cfg_nmi = 1'b0;
    logic       aerr_set = 1'b0;
    logic       nmi_set = 1'b0;
    logic [3:0] gnt;
    logic       gnt_valid;
    logic       st_en;
    logic [1:0] st_mode;
    logic       st_aerr;
    logic       st_nmi;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    logic       m_en = 0, m_aerr = 0, m_nmi = 0, m_busy = 0;
    logic [1:0] m_mode = 0;
    int         m_own = 0, m_ptr = 0;

    dma_grant_arbiter uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int pick_ref(input logic [1:0] mode, input int ptr, input logic [3:0] r);
        int ord [4];
        case (mode)
            2'd0: ord = '{0, 1, 2, 3};
            2'd1: ord = '{0, 2, 3, 1};
            2'd2: ord = '{2, 0, 1, 3};
            default: for (int i = 0; i < 4; i++) ord[i] = (ptr + i) % 4;
        endcase
        for (int i = 0; i < 4; i++) if (r[ord[i]]) return ord[i];
        return 0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock cycle with the model advanced and outputs compared.
    task automatic cycle(input string tag);
        logic allowed, n_en, n_aerr, n_nmi, n_busy;
        logic [1:0] n_mode;
        logic [3:0] e_gnt;
        int n_own, n_ptr;
        allowed = m_en && !m_aerr && !m_nmi;
        n_en   = cfg_we ? cfg_en : m_en;
        n_mode = cfg_we ? cfg_mode : m_mode;
        n_aerr = aerr_set || (m_aerr && !(cfg_we && !cfg_aerr));
        n_nmi  = nmi_set  || (m_nmi  && !(cfg_we && !cfg_nmi));
        n_busy = m_busy; n_own = m_own; n_ptr = m_ptr;
        if (!allowed) n_busy = 0;
        else if (m_busy) begin
            if (unit_done) n_busy = 0;
        end else if (req != 0) begin
            n_busy = 1;
            n_own  = pick_ref(m_mode, m_ptr, req);
            n_ptr  = (n_own + 1) % 4;
        end
        @(posedge clk); #1;
        m_en = n_en; m_mode = n_mode; m_aerr = n_aerr; m_nmi = n_nmi;
        m_busy = n_busy; m_own = n_own; m_ptr = n_ptr;
        e_gnt = (m_busy && m_en && !m_aerr && !m_nmi) ? 4'(1 << m_own) : 4'd0;
        check(tag, {23'd0, gnt_valid, gnt, st_en, st_mode, st_aerr, st_nmi},
              {23'd0, (e_gnt != 0), e_gnt, m_en, m_mode, m_aerr, m_nmi});
    endtask

    task automatic write_cfg(input logic en, input logic [1:0] mode,
                             input logic ae, input logic nm, input string tag);
        cfg_we = 1; cfg_en = en; cfg_mode = mode; cfg_aerr = ae; cfg_nmi = nm;
        cycle(tag);
        cfg_we = 0;
    endtask

    // Award one grant from idle, check the winner, then release it.
    task automatic grant_once(input logic [1:0] mode, input logic [3:0] r,
                              input logic [3:0] exp, input string tag);
        write_cfg(1, mode, 1, 1, tag);
        req = r;
        cycle(tag);
        check(tag, gnt, exp);
        req = 0; unit_done = 1;
        cycle(tag);
        unit_done = 0;
        check(tag, gnt, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        check("R1", {gnt_valid, gnt, st_en, st_mode, st_aerr, st_nmi}, 0);
        cycle("R1");

        // R5: rotation starts at channel 0 after reset
        grant_once(2'd3, 4'b1111, 4'b0001, "R5");
        // R2: numeric ranking
        grant_once(2'd0, 4'b1110, 4'b0010, "R2");
        grant_once(2'd0, 4'b1100, 4'b0100, "R2");
        // R3: 0 > 2 > 3 > 1
        grant_once(2'd1, 4'b1010, 4'b1000, "R3");
        grant_once(2'd1, 4'b1110, 4'b0100, "R3");
        // R4: 2 > 0 > 1 > 3
        grant_once(2'd2, 4'b0011, 4'b0001, "R4");
        grant_once(2'd2, 4'b1111, 4'b0100, "R4");
        // R5: pointer now 3, then wraps
        grant_once(2'd3, 4'b1111, 4'b1000, "R5");
        grant_once(2'd3, 4'b1111, 4'b0001, "R5");
        grant_once(2'd3, 4'b0001, 4'b0001, "R5");
        grant_once(2'd3, 4'b1101, 4'b0100, "R5");
        // R5: idle cycles leave the pointer at 3
        repeat (4) cycle("R5");
        grant_once(2'd3, 4'b1011, 4'b1000, "R5");

        // R6: hold against request and order changes
        write_cfg(1, 2'd0, 1, 1, "R6");
        req = 4'b0001;
        cycle("R6");
        check("R6", gnt, 4'b0001);
        req = 4'b1111;
        write_cfg(1, 2'd2, 1, 1, "R6");
        check("R6", gnt, 4'b0001);
        cycle("R6");
        check("R6", gnt, 4'b0001);
        unit_done = 1;
        cycle("R6");
        unit_done = 0;
        check("R6", gnt, 4'b0000);
        cycle("R6");
        check("R6", gnt, 4'b0100);

        // R7: clearing the enable kills the grant, no resume
        write_cfg(0, 2'd2, 1, 1, "R7");
        check("R7", gnt, 4'b0000);
        req = 0;
        write_cfg(1, 2'd2, 1, 1, "R7");
        cycle("R7");
        check("R7", gnt, 4'b0000);

        // R8: address-error flag
        req = 4'b0010;
        cycle("R8");
        check("R8", gnt, 4'b0010);
        aerr_set = 1;
        cycle("R8");
        aerr_set = 0;
        check("R8", {st_aerr, gnt}, {1'b1, 4'b0000});
        write_cfg(1, 2'd2, 1, 1, "R10");
        check("R10", {st_aerr, gnt}, {1'b1, 4'b0000});
        aerr_set = 1;
        write_cfg(1, 2'd2, 0, 1, "R10");
        aerr_set = 0;
        check("R10", st_aerr, 1'b1);
        write_cfg(1, 2'd2, 0, 1, "R10");
        check("R10", {st_aerr, gnt}, {1'b0, 4'b0000});
        cycle("R8");
        check("R8", gnt, 4'b0010);

        // R9: NMI flag
        nmi_set = 1;
        cycle("R9");
        nmi_set = 0;
        check("R9", {st_nmi, gnt_valid}, {1'b1, 1'b0});
        write_cfg(1, 2'd2, 1, 0, "R9");
        check("R9", st_nmi, 1'b0);
        req = 0;
        cycle("R9");
        check("R9", gnt, 4'b0000);

        // Random stimulus against the model
        void'($urandom(32'd5489));
        for (int n = 0; n < 4000; n++) begin
            req       = 4'($urandom);
            unit_done = ($urandom % 2) == 0;
            aerr_set  = ($urandom % 64) == 0;
            nmi_set   = ($urandom % 64) == 0;
            cfg_we    = ($urandom % 12) == 0;
            cfg_en    = ($urandom % 8) != 0;
            cfg_mode  = 2'($urandom);
            cfg_aerr  = ($urandom % 4) != 0;
            cfg_nmi   = ($urandom % 4) != 0;
            cycle(n % 2 == 0 ? "R6" : "R11");
        end
        req = 0; unit_done = 0; aerr_set = 0; nmi_set = 0; cfg_we = 0;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule